// File: doc/BRIEF.md
# Readout Frame Header Capture

This block follows the serial-to-parallel ADC path of a multiplexed analogue readout. Each front-end chip sends frames made of 16 header slots and then 128 analogue channel slots, with one slot per cycle of the slot clock (25 ns each). When a frame-start pulse arrives, the lane for that chip produces a header sample strobe for each header slot and a channel sample strobe with a running channel index for each channel slot. The channel strobes go to the existing channel data path. The digitised header words are not discarded. They go into a header FIFO that belongs to that chip, so the chip's status information travels with every event.

There is one lane per front-end chip, and each lane has its own FIFO. A frame's header becomes visible to the reader only after all 16 of its words have been written. If a frame cannot fit when it starts, it is dropped as a whole and a sticky overflow flag is raised. A start pulse that arrives while a frame is still in progress is ignored and raises a sticky error flag. A per-chip enable mask removes a chip from operation completely. A round-robin arbiter joins the FIFOs of all chips into one valid/ready read port. It hands out whole frames, and each word is tagged with the chip it came from.

Top module: `hdr_capture`

## Requirements
- R1: A frame start is sampled while the lane is idle and its enable bit is 1. After such a start, the header strobe is high for the next 16 slot cycles. The channel strobe is then high for the following 128 cycles, and after that both strobes are low. The two strobes are never high together.
- R2: During the channel slots the channel index output counts 0, 1, ... 127, one step per slot. Outside channel slots it is 0.
- R3: The data input is sampled in each header-strobe cycle, and those words are stored in arrival order. On the read port a frame comes out as its 16 words, slot 0 first, with the read chip output equal to the chip number.
- R4: While a frame's header slots are in progress, no word of that frame is offered on the read port. When nothing older is stored, the read valid output stays 0 during those slots.
- R5: At an accepted start the FIFO may hold fewer than 16 free entries. In that case no word of the frame is stored, the sticky overflow bit of that chip is 1 from the next cycle on, and frames stored earlier are still read out intact.
- R6: A frame start during any slot of a running frame, including its last channel slot, leaves the running frame unchanged. The sticky error bit of that chip is 1 from the next cycle on. A start in the first cycle after the last slot is accepted without error.
- R7: A frame start for a chip whose enable bit is 0 produces no strobes, stores nothing and sets no flag.
- R8: The read port serves complete frames. After reset it looks at chip 0 first. Once a frame from chip c has been read, the next frame comes from the next chip after c, in rising order with wrap-around, that has a complete frame stored.
- R9: While read valid is 1 and read ready is 0, read valid, read data and read chip stay unchanged.
- R10: In reset and right after it, all strobes, the channel index, both flag outputs and read valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock, one cycle per slot |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | NCHIP | Frame-start pulse, one bit per chip |
| chip_en_i | input | NCHIP | Enable mask, one bit per chip |
| adc_data_i | input | NCHIP*DW | Digitised sample per chip, chip 0 in the low bits |
| hdr_stb_o | output | NCHIP | Header-slot sample strobe per chip |
| chan_stb_o | output | NCHIP | Channel-slot sample strobe per chip |
| chan_idx_o | output | NCHIP*CIW | Channel index per chip |
| err_o | output | NCHIP | Sticky start-during-frame flag per chip |
| ovf_o | output | NCHIP | Sticky header-overflow flag per chip |
| rd_valid_o | output | 1 | Read word valid |
| rd_ready_i | input | 1 | Reader accepts the word |
| rd_data_o | output | DW | Header word |
| rd_chip_o | output | CHW | Chip number of the word |

## Verification
A start pulse is sampled at clock edge 0. The header strobes follow in the 16 cycles after that edge, and each cycle's data is sampled at the edge that ends the cycle. The channel strobes come in cycles 17 to 144, and the lane is idle again from cycle 145. The overflow and error flags appear one edge after the pulse that causes them. The bench drives inputs on falling edges and compares each output shortly after the falling edge of the cycle it belongs to. A completed frame enters the expected-word queue in the cycle after its commit edge, and the read port is only drained while no frame is running. This way the round-robin choice the bench predicts is made from the same set of stored frames that the arbiter sees.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_CHAN = 2'd2
  } phase_e;
endpackage

// File: rtl/hdr_slot_seq.sv
module hdr_slot_seq
  import hdr_pkg::*;
#(
  parameter int HDR_SLOTS  = 16,
  parameter int CHAN_SLOTS = 128,
  localparam int CW  = $clog2((HDR_SLOTS > CHAN_SLOTS) ? HDR_SLOTS : CHAN_SLOTS),
  localparam int CIW = $clog2(CHAN_SLOTS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           en_i,
  input  logic           fits_i,
  output logic           hdr_stb_o,
  output logic           chan_stb_o,
  output logic [CIW-1:0] idx_o,
  output logic           wr_o,
  output logic           commit_o,
  output logic           err_o,
  output logic           ovf_o
);
  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      keep_q  <= 1'b0;
      err_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (start_i && en_i && phase_q != PH_IDLE) err_o <= 1'b1;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i && en_i) begin
            phase_q <= PH_HDR;
            cnt_q   <= '0;
            keep_q  <= fits_i;  // whole-frame decision at start
            if (!fits_i) ovf_o <= 1'b1;
          end
        end
        PH_HDR: begin
          if (cnt_q == CW'(HDR_SLOTS - 1)) begin
            phase_q <= PH_CHAN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CHAN: begin
          if (cnt_q == CW'(CHAN_SLOTS - 1)) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign hdr_stb_o  = (phase_q == PH_HDR);
  assign chan_stb_o = (phase_q == PH_CHAN);
  assign idx_o      = chan_stb_o ? cnt_q[CIW-1:0] : '0;
  assign wr_o       = hdr_stb_o && keep_q;
  assign commit_o   = wr_o && (cnt_q == CW'(HDR_SLOTS - 1));
endmodule

// File: rtl/hdr_frame_fifo.sv
module hdr_frame_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 32,
  parameter int FRAME = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          commit_i,
  input  logic          pop_i,
  output logic          fits_o,
  output logic          avail_o,
  output logic [DW-1:0] head_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wptr_q, cptr_q, rptr_q;
  logic [AW:0]   used;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wptr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_i) wptr_q <= wptr_q + 1'b1;
      if (commit_i) cptr_q <= wptr_q + 1'b1;  // commit with last write
      if (pop_i) rptr_q <= rptr_q + 1'b1;
    end
  end

  // reader sees committed words only
  assign used    = cptr_q - rptr_q;
  assign fits_o  = (32'(used) + FRAME) <= DEPTH;
  assign avail_o = (cptr_q != rptr_q);
  assign head_o  = mem_q[rptr_q[AW-1:0]];
endmodule

// File: rtl/hdr_rd_arb.sv
module hdr_rd_arb #(
  parameter int NCHIP = 2,
  parameter int FRAME = 16,
  localparam int CHW = (NCHIP > 1) ? $clog2(NCHIP) : 1,
  localparam int WCW = $clog2(FRAME)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCHIP-1:0] avail_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [CHW-1:0]   sel_o,
  output logic [NCHIP-1:0] pop_o
);
  logic           lock_q;
  logic [CHW-1:0] cur_q, last_q, nxt;
  logic [WCW-1:0] wc_q;
  logic           found;

  always_comb begin
    nxt   = last_q;
    found = 1'b0;
    for (int i = 1; i <= NCHIP; i++) begin
      int idx;
      idx = (int'(last_q) + i) % NCHIP;
      if (!found && avail_i[idx]) begin
        nxt   = CHW'(idx);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      cur_q  <= '0;
      last_q <= CHW'(NCHIP - 1);
      wc_q   <= '0;
    end else if (!lock_q) begin
      if (found) begin
        lock_q <= 1'b1;
        cur_q  <= nxt;
        wc_q   <= '0;
      end
    end else if (rd_ready_i) begin
      if (wc_q == WCW'(FRAME - 1)) begin
        lock_q <= 1'b0;
        last_q <= cur_q;
        wc_q   <= '0;
      end else begin
        wc_q <= wc_q + 1'b1;
      end
    end
  end

  assign rd_valid_o = lock_q;
  assign sel_o      = cur_q;

  for (genvar c = 0; c < NCHIP; c++) begin : g_pop
    assign pop_o[c] = lock_q && rd_ready_i && (cur_q == CHW'(c));
  end
endmodule

// File: rtl/hdr_capture.sv
module hdr_capture #(
  parameter int NCHIP      = 2,
  parameter int DW         = 12,
  parameter int HDR_SLOTS  = 16,
  parameter int CHAN_SLOTS = 128,
  parameter int HDR_DEPTH  = 32,
  localparam int CIW = $clog2(CHAN_SLOTS),
  localparam int CHW = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCHIP-1:0]     frame_start_i,
  input  logic [NCHIP-1:0]     chip_en_i,
  input  logic [NCHIP*DW-1:0]  adc_data_i,
  output logic [NCHIP-1:0]     hdr_stb_o,
  output logic [NCHIP-1:0]     chan_stb_o,
  output logic [NCHIP*CIW-1:0] chan_idx_o,
  output logic [NCHIP-1:0]     err_o,
  output logic [NCHIP-1:0]     ovf_o,
  output logic                 rd_valid_o,
  input  logic                 rd_ready_i,
  output logic [DW-1:0]        rd_data_o,
  output logic [CHW-1:0]       rd_chip_o
);
  logic [NCHIP-1:0] fits, wr, commit, avail, pop;
  logic [DW-1:0]    head [NCHIP];

  for (genvar c = 0; c < NCHIP; c++) begin : g_lane
    hdr_slot_seq #(
      .HDR_SLOTS (HDR_SLOTS),
      .CHAN_SLOTS(CHAN_SLOTS)
    ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (frame_start_i[c]),
      .en_i      (chip_en_i[c]),
      .fits_i    (fits[c]),
      .hdr_stb_o (hdr_stb_o[c]),
      .chan_stb_o(chan_stb_o[c]),
      .idx_o     (chan_idx_o[c*CIW +: CIW]),
      .wr_o      (wr[c]),
      .commit_o  (commit[c]),
      .err_o     (err_o[c]),
      .ovf_o     (ovf_o[c])
    );

    hdr_frame_fifo #(
      .DW   (DW),
      .DEPTH(HDR_DEPTH),
      .FRAME(HDR_SLOTS)
    ) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr[c]),
      .wdata_i (adc_data_i[c*DW +: DW]),
      .commit_i(commit[c]),
      .pop_i   (pop[c]),
      .fits_o  (fits[c]),
      .avail_o (avail[c]),
      .head_o  (head[c])
    );
  end

  hdr_rd_arb #(
    .NCHIP(NCHIP),
    .FRAME(HDR_SLOTS)
  ) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .avail_i   (avail),
    .rd_ready_i(rd_ready_i),
    .rd_valid_o(rd_valid_o),
    .sel_o     (rd_chip_o),
    .pop_o     (pop)
  );

  assign rd_data_o = head[rd_chip_o];
endmodule

// File: rtl/hdr_capture_chk.sv
module hdr_capture_chk #(
  parameter int NCHIP = 2,
  parameter int DW    = 12,
  parameter int CIW   = 7,
  parameter int CHW   = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NCHIP-1:0]     frame_start_i,
  input logic [NCHIP-1:0]     chip_en_i,
  input logic [NCHIP*DW-1:0]  adc_data_i,
  input logic [NCHIP-1:0]     hdr_stb_o,
  input logic [NCHIP-1:0]     chan_stb_o,
  input logic [NCHIP*CIW-1:0] chan_idx_o,
  input logic [NCHIP-1:0]     err_o,
  input logic [NCHIP-1:0]     ovf_o,
  input logic                 rd_valid_o,
  input logic                 rd_ready_i,
  input logic [DW-1:0]        rd_data_o,
  input logic [CHW-1:0]       rd_chip_o
);
  // R9
  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) && $stable(rd_chip_o));

  for (genvar c = 0; c < NCHIP; c++) begin : g_c
    assert_excl_stb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hdr_stb_o[c] && chan_stb_o[c]));

    assert_idx_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chan_stb_o[c] && $past(chan_stb_o[c]) |->
        chan_idx_o[c*CIW +: CIW] == $past(chan_idx_o[c*CIW +: CIW]) + CIW'(1));

    assert_ovf_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_o[c]) |-> $past(frame_start_i[c] && chip_en_i[c]));

    assert_err_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o[c]) |-> $past(frame_start_i[c] && (hdr_stb_o[c] || chan_stb_o[c])));

    assert_mask_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hdr_stb_o[c]) |-> $past(frame_start_i[c] && chip_en_i[c]));
  end
endmodule

bind hdr_capture hdr_capture_chk #(
  .NCHIP(NCHIP),
  .DW   (DW),
  .CIW  (CIW),
  .CHW  (CHW)
) u_chk (.*);

// File: tb/sim_hdr_capture.sv
module sim_hdr_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NC    = 2;
  localparam int DW    = 12;
  localparam int CIW   = 7;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] fs = '0, en = '0;
  logic [NC*DW-1:0] adc = '0;
  logic [NC-1:0] hdr_stb, chan_stb, err, ovf;
  logic [NC*CIW-1:0] cidx;
  logic rd_valid, rdy = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_chip;

  int checks = 0, fails = 0;
  logic [DW-1:0] q0 [$];
  logic [DW-1:0] q1 [$];
  logic [NC-1:0] err_exp = '0, ovf_exp = '0;
  int last_m = 1, wc_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .chip_en_i(en),
    .adc_data_i(adc), .hdr_stb_o(hdr_stb), .chan_stb_o(chan_stb),
    .chan_idx_o(cidx), .err_o(err), .ovf_o(ovf), .rd_valid_o(rd_valid),
    .rd_ready_i(rdy), .rd_data_o(rd_data), .rd_chip_o(rd_chip)
  );

  function automatic int qsize(int c);
    return (c == 0) ? q0.size() : q1.size();
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: compares read-port words with scoreboard queues
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rd_valid && rdy) begin
        logic [DW-1:0] e;
        if (wc_m == 0) begin
          int pref, ec;
          pref = (last_m + 1) % NC;
          ec = (qsize(pref) > 0) ? pref : last_m;
          chk(int'(rd_chip) == ec, "R8 frame chip order", int'(rd_chip), ec);
        end
        if (qsize(int'(rd_chip)) == 0) begin
          chk(1'b0, "R3 unexpected word", int'(rd_data), -1);
        end else begin
          e = (rd_chip == 1'b0) ? q0.pop_front() : q1.pop_front();
          chk(rd_data == e, "R3 header word", int'(rd_data), int'(e));
        end
        wc_m++;
        if (wc_m == 16) begin
          wc_m = 0;
          last_m = int'(rd_chip);
        end
      end
    end
  end

  // driver: entered and left on a falling edge
  task automatic run_frame(input logic [NC-1:0] starts, input logic [NC-1:0] ena,
                           input int tag, input int nk, input int extra_k, input int extra_c);
    logic [NC-1:0] acc, keep;
    int bad[NC];
    bit idle_rd;
    en = ena;
    fs = starts;
    idle_rd = (q0.size() == 0) && (q1.size() == 0);
    for (int c = 0; c < NC; c++) begin
      acc[c]  = starts[c] && ena[c];
      keep[c] = acc[c] && (qsize(c) + 16 <= DEPTH);
      if (acc[c] && !keep[c]) ovf_exp[c] = 1'b1;
      bad[c] = 0;
    end
    for (int k = 1; k <= nk; k++) begin
      @(negedge clk);
      fs = '0;
      if (k == extra_k) fs[extra_c] = 1'b1;
      for (int c = 0; c < NC; c++) begin
        adc[c*DW +: DW] = {c[0], tag[6:0], 4'((k - 1) & 15)};
        if (k == 17 && keep[c]) begin
          for (int s = 0; s < 16; s++) begin
            if (c == 0) q0.push_back({1'b0, tag[6:0], 4'(s)});
            else q1.push_back({1'b1, tag[6:0], 4'(s)});
          end
        end
      end
      #1;
      for (int c = 0; c < NC; c++) begin
        bit eh, ec;
        eh = acc[c] && k <= 16;
        ec = acc[c] && k >= 17 && k <= 144;
        if (hdr_stb[c] != eh || chan_stb[c] != ec) bad[c]++;
        if (ec && int'(cidx[c*CIW +: CIW]) != k - 17) bad[c]++;
        if (!ec && cidx[c*CIW +: CIW] != '0) bad[c]++;
      end
      if (k == 1)
        chk(ovf == ovf_exp, "R5 overflow flag", int'(ovf), int'(ovf_exp));
      if (k == 10 && idle_rd)
        chk(rd_valid == 1'b0, "R4 partial frame hidden", int'(rd_valid), 0);
      if (extra_k > 0 && k == extra_k + 1) begin
        if (acc[extra_c] && extra_k <= 144) err_exp[extra_c] = 1'b1;
        chk(err == err_exp, "R6 error flag", int'(err), int'(err_exp));
      end
    end
    for (int c = 0; c < NC; c++) begin
      string m;
      m = ena[c] ? "R1 R2 strobe pattern" : "R7 masked chip strobes";
      chk(bad[c] == 0, m, bad[c], 0);
    end
    chk(err == err_exp, "R6 R7 error flags", int'(err), int'(err_exp));
    chk(ovf == ovf_exp, "R5 R7 overflow flags", int'(ovf), int'(ovf_exp));
  endtask

  task automatic drain();
    int n = 0;
    rdy = 1'b1;
    while ((q0.size() != 0 || q1.size() != 0) && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(rd_valid == 1'b0, "R3 R5 no extra words", int'(rd_valid), 0);
    chk(q0.size() + q1.size() == 0, "R3 all words read", q0.size() + q1.size(), 0);
    rdy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10
    chk({hdr_stb, chan_stb, err, ovf, rd_valid} == '0, "R10 outputs in reset",
        int'({hdr_stb, chan_stb, err, ovf, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({hdr_stb, chan_stb, cidx, err, ovf, rd_valid} == '0, "R10 outputs after reset",
        int'({hdr_stb, chan_stb, err, ovf, rd_valid}), 0);

    run_frame(2'b01, 2'b11, 1, 146, 0, 0);   // R1 R2 R3 R4 single chip
    drain();
    run_frame(2'b11, 2'b11, 2, 146, 0, 0);   // R8 both chips
    drain();
    run_frame(2'b11, 2'b01, 3, 146, 0, 0);   // R7 chip 1 masked
    drain();
    run_frame(2'b01, 2'b11, 4, 146, 0, 0);   // R5 fill then overflow
    run_frame(2'b01, 2'b11, 5, 146, 0, 0);
    run_frame(2'b01, 2'b11, 6, 146, 0, 0);
    drain();
    run_frame(2'b01, 2'b11, 7, 145, 0, 0);   // R6 back-to-back accepted
    run_frame(2'b01, 2'b11, 8, 146, 0, 0);
    drain();
    run_frame(2'b10, 2'b11, 9, 146, 144, 1); // R6 start on last slot
    drain();
    run_frame(2'b01, 2'b11, 10, 146, 50, 0); // R6 start mid-frame
    drain();
    run_frame(2'b11, 2'b11, 11, 146, 0, 0);  // R8 order after chip 0 last
    drain();

    summary();
    $finish;
  end
endmodule